// File: doc/BRIEF.md
# Two-Region Cache Set Swap Controller

This block keeps the tag, valid and recency state of a set-associative cache whose ways are divided into two groups: a small group reached over a cheap path (the low-power group, LP) and the remaining ways reached over an expensive path (the high-power group, HP). Each lookup compares the requested tag against every way of the addressed set at once. It answers with an LP hit, an HP hit or a miss, together with the way involved.

While block movement is enabled, a block found in the HP group is moved into the LP group. It is exchanged with the least-recently-used LP block, so the LP ways keep the most-recently-used blocks of each set. A miss is filled into the LP group, and the LP block it displaces is pushed into the oldest HP way, whose block is evicted. Every region access the controller causes appears as a one-cycle pulse on `lp_access` or `hp_access`, so that an external tally can account for energy.

A single saturating five-bit reuse count serves the whole cache. It rises on LP hits and falls on every other outcome. When the count drops below a threshold, movement stops and the block behaves as an ordinary cache with least-recently-used replacement over all ways. Requests use a valid/ready handshake. Ready drops for one cycle while a two-phase move is being reported.

Top module: `cs_swap_ctrl`

## Requirements
- R1: Ways 0 to LP_WAYS-1 (default 0 and 1 of 8) form the LP group and all higher ways form the HP group. `resp_way` reports the way that hit, or for a miss the way that was filled.
- R2: A request accepted at a clock edge (req_valid and req_ready high) produces resp_valid for exactly the next cycle. In that cycle resp_kind is 2'b01 for an LP hit, 2'b10 for an HP hit and 2'b00 for a miss. Only accepted requests produce responses.
- R3: An LP hit gives one lp_access pulse in the response cycle, no hp_access, and no change of placement.
- R4: An HP hit with movement enabled exchanges the hit block with the LP least-recently-used block. It pulses lp_access and hp_access together in the response cycle and again in the following cycle.
- R5: Recency is a per-set age order. Every hit or fill makes the touched way the most recent. The LP victim is the LP way touched longest ago.
- R6: A miss with movement enabled fills the LP least-recently-used way, moves its old block into the oldest HP way, and evicts that way's block. It pulses lp_access alone in the response cycle, then lp_access and hp_access in the following cycle.
- R7: The reuse count resets to 31, adds one on an LP hit (holding at 31), and subtracts one on any other outcome (holding at 0). Movement is enabled while the count is at least THRESH (default 16). policy_on shows this, reflecting the count after the lookup in the response cycle. Each lookup is classified with the count value from before it.
- R8: With movement disabled, an HP hit stays in place with a single hp_access pulse. A miss fills the lowest-numbered invalid way, or else the least-recently-used way of the whole set, with one pulse for that way's region. Ready does not drop.
- R9: req_ready is low for exactly the cycle after a two-phase move is accepted. A request presented while ready is low is not accepted and has no effect.
- R10: Sets are independent: a lookup changes only the addressed set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_set | input | SET_W (4) | Set index of the request |
| req_tag | input | TAG_W (12) | Tag of the request |
| resp_valid | output | 1 | Lookup result present |
| resp_kind | output | 2 | 00 miss, 01 LP hit, 10 HP hit |
| resp_way | output | WAY_W (3) | Way that hit or was filled |
| lp_access | output | 1 | One LP-region access this cycle |
| hp_access | output | 1 | One HP-region access this cycle |
| policy_on | output | 1 | Block movement enabled |

## Verification
The response, policy_on and the first access phase are due in the cycle after the accepting edge. The second access phase of a move is due one cycle later, and ready is low in between. The bench drives and samples on the falling edge. The driver pushes a predicted item when it raises a request whose ready it has already seen high. The monitor pops that item when resp_valid appears and keeps any second-phase expectation pending for the next falling edge. A request raised while ready is low must never yield a response, and any response with nothing queued is reported.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [1:0] {
        KIND_MISS = 2'd0,
        KIND_LP   = 2'd1,
        KIND_HP   = 2'd2
    } hit_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MOVE = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic lp;
        logic hp;
    } evt_t;

endpackage

// File: rtl/cs_tag_store.sv
module cs_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 8,
    parameter int TAG_W = 12,
    parameter int AGE_W = 3,
    parameter int SET_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0][AGE_W-1:0]   rd_age,
    input  logic                         wr_en,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [WAYS-1:0][TAG_W-1:0]   wr_tag,
    input  logic [WAYS-1:0]              wr_valid,
    input  logic [WAYS-1:0][AGE_W-1:0]   wr_age
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age;
    } store_t;

    store_t st_d, st_q, st_rst;

    // reset image: nothing valid, ages form the order 0..WAYS-1
    always_comb begin
        st_rst = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                st_rst.age[s][w] = AGE_W'(w);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tag[wr_set]   = wr_tag;
            st_d.valid[wr_set] = wr_valid;
            st_d.age[wr_set]   = wr_age;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign rd_tag   = st_q.tag[rd_set];
    assign rd_valid = st_q.valid[rd_set];
    assign rd_age   = st_q.age[rd_set];

endmodule

// File: rtl/cs_lookup.sv
module cs_lookup
    import cs_pkg::*;
#(
    parameter int WAYS    = 8,
    parameter int LP_WAYS = 2,
    parameter int TAG_W   = 12,
    parameter int AGE_W   = 3,
    parameter int WAY_W   = 3
) (
    input  logic [WAYS-1:0][TAG_W-1:0]  cur_tag,
    input  logic [WAYS-1:0]             cur_valid,
    input  logic [WAYS-1:0][AGE_W-1:0]  cur_age,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic                        move_on,
    output hit_kind_e                   kind,
    output logic [WAY_W-1:0]            way,
    output logic [WAYS-1:0][TAG_W-1:0]  nxt_tag,
    output logic [WAYS-1:0]             nxt_valid,
    output logic [WAYS-1:0][AGE_W-1:0]  nxt_age,
    output evt_t                        ev1,
    output evt_t                        ev2,
    output logic                        two_phase
);

    typedef logic [WAYS-1:0][AGE_W-1:0] age_vec_t;

    // make way w the most recent; ways younger than it age by one
    function automatic age_vec_t touch(input age_vec_t a, input logic [WAY_W-1:0] w);
        age_vec_t r;
        r = a;
        for (int i = 0; i < WAYS; i++) begin
            if (a[i] < a[w]) r[i] = a[i] + 1'b1;
        end
        r[w] = '0;
        return r;
    endfunction

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             hit_in_lp;
    logic [WAY_W-1:0] lp_lru, hp_lru, all_lru, inv_way, victim;
    logic [AGE_W-1:0] lp_best, hp_best, all_best;
    logic             any_inv;

    // parallel tag compare, lowest matching way wins
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (cur_valid[w] && (cur_tag[w] == req_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        hit_in_lp = hit && (32'(hit_way) < LP_WAYS);
    end

    // oldest way of each group and of the whole set
    always_comb begin
        lp_lru  = '0;
        lp_best = '0;
        for (int w = 0; w < LP_WAYS; w++) begin
            if (cur_age[w] >= lp_best) begin
                lp_best = cur_age[w];
                lp_lru  = WAY_W'(w);
            end
        end
        hp_lru  = WAY_W'(LP_WAYS);
        hp_best = '0;
        for (int w = LP_WAYS; w < WAYS; w++) begin
            if (cur_age[w] >= hp_best) begin
                hp_best = cur_age[w];
                hp_lru  = WAY_W'(w);
            end
        end
        all_lru  = '0;
        all_best = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (cur_age[w] >= all_best) begin
                all_best = cur_age[w];
                all_lru  = WAY_W'(w);
            end
        end
    end

    // conventional victim: first empty way, else oldest of the set
    always_comb begin
        any_inv = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!cur_valid[w]) begin
                any_inv = 1'b1;
                inv_way = WAY_W'(w);
            end
        end
        victim = any_inv ? inv_way : all_lru;
    end

    // outcome and new set image
    always_comb begin
        nxt_tag   = cur_tag;
        nxt_valid = cur_valid;
        nxt_age   = cur_age;
        ev1       = '0;
        ev2       = '0;
        two_phase = 1'b0;
        kind      = KIND_MISS;
        way       = '0;
        if (hit_in_lp) begin
            kind    = KIND_LP;
            way     = hit_way;
            nxt_age = touch(cur_age, hit_way);
            ev1.lp  = 1'b1;
        end else if (hit && move_on) begin
            kind               = KIND_HP;
            way                = hit_way;
            nxt_tag[lp_lru]    = cur_tag[hit_way];
            nxt_valid[lp_lru]  = cur_valid[hit_way];
            nxt_age[lp_lru]    = cur_age[hit_way];
            nxt_tag[hit_way]   = cur_tag[lp_lru];
            nxt_valid[hit_way] = cur_valid[lp_lru];
            nxt_age[hit_way]   = cur_age[lp_lru];
            nxt_age            = touch(nxt_age, lp_lru);
            ev1                = '{lp: 1'b1, hp: 1'b1};
            ev2                = '{lp: 1'b1, hp: 1'b1};
            two_phase          = 1'b1;
        end else if (hit) begin
            kind    = KIND_HP;
            way     = hit_way;
            nxt_age = touch(cur_age, hit_way);
            ev1.hp  = 1'b1;
        end else if (move_on) begin
            way               = lp_lru;
            nxt_tag[hp_lru]   = cur_tag[lp_lru];
            nxt_valid[hp_lru] = cur_valid[lp_lru];
            nxt_age[hp_lru]   = cur_age[lp_lru];
            nxt_age[lp_lru]   = cur_age[hp_lru];
            nxt_tag[lp_lru]   = req_tag;
            nxt_valid[lp_lru] = 1'b1;
            nxt_age           = touch(nxt_age, lp_lru);
            ev1.lp            = 1'b1;
            ev2               = '{lp: 1'b1, hp: 1'b1};
            two_phase         = 1'b1;
        end else begin
            way               = victim;
            nxt_tag[victim]   = req_tag;
            nxt_valid[victim] = 1'b1;
            nxt_age           = touch(cur_age, victim);
            ev1.lp            = (32'(victim) < LP_WAYS);
            ev1.hp            = !(32'(victim) < LP_WAYS);
        end
    end

endmodule

// File: rtl/cs_reuse_ctr.sv
module cs_reuse_ctr #(
    parameter int CNT_W  = 5,
    parameter int THRESH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic lp_hit,
    output logic move_on
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (upd) begin
            if (lp_hit) begin
                if (ctr_q.cnt != '1) ctr_d.cnt = ctr_q.cnt + 1'b1;
            end else begin
                if (ctr_q.cnt != '0) ctr_d.cnt = ctr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '{cnt: '1};
        else        ctr_q <= ctr_d;
    end

    assign move_on = (ctr_q.cnt >= CNT_W'(THRESH));

endmodule

// File: rtl/cs_swap_ctrl.sv
module cs_swap_ctrl
    import cs_pkg::*;
#(
    parameter int SETS    = 16,
    parameter int WAYS    = 8,
    parameter int LP_WAYS = 2,
    parameter int TAG_W   = 12,
    parameter int CNT_W   = 5,
    parameter int THRESH  = 16,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int AGE_W  = WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SET_W-1:0]  req_set,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic [WAY_W-1:0]  resp_way,
    output logic              lp_access,
    output logic              hp_access,
    output logic              policy_on
);

    typedef struct packed {
        ctl_state_e       st;
        logic             rv;
        hit_kind_e        kind;
        logic [WAY_W-1:0] way;
        evt_t             ev;
        evt_t             ev2;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WAYS-1:0][TAG_W-1:0] set_tag, new_tag;
    logic [WAYS-1:0]            set_valid, new_valid;
    logic [WAYS-1:0][AGE_W-1:0] set_age, new_age;
    hit_kind_e                  lk_kind;
    logic [WAY_W-1:0]           lk_way;
    evt_t                       lk_ev1, lk_ev2;
    logic                       lk_two;
    logic                       accept;
    logic                       move_on;

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign accept    = req_valid && req_ready;

    cs_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .SET_W(SET_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_set),
        .rd_tag   (set_tag),
        .rd_valid (set_valid),
        .rd_age   (set_age),
        .wr_en    (accept),
        .wr_set   (req_set),
        .wr_tag   (new_tag),
        .wr_valid (new_valid),
        .wr_age   (new_age)
    );

    cs_lookup #(
        .WAYS(WAYS), .LP_WAYS(LP_WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)
    ) u_lookup (
        .cur_tag   (set_tag),
        .cur_valid (set_valid),
        .cur_age   (set_age),
        .req_tag   (req_tag),
        .move_on   (move_on),
        .kind      (lk_kind),
        .way       (lk_way),
        .nxt_tag   (new_tag),
        .nxt_valid (new_valid),
        .nxt_age   (new_age),
        .ev1       (lk_ev1),
        .ev2       (lk_ev2),
        .two_phase (lk_two)
    );

    cs_reuse_ctr #(
        .CNT_W(CNT_W), .THRESH(THRESH)
    ) u_reuse (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (accept),
        .lp_hit  (lk_kind == KIND_LP),
        .move_on (move_on)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rv  = 1'b0;
        ctl_d.ev  = '0;
        ctl_d.ev2 = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.rv   = 1'b1;
                    ctl_d.kind = lk_kind;
                    ctl_d.way  = lk_way;
                    ctl_d.ev   = lk_ev1;
                    ctl_d.ev2  = lk_ev2;
                    ctl_d.st   = lk_two ? ST_MOVE : ST_IDLE;
                end
            end
            ST_MOVE: begin
                ctl_d.ev = ctl_q.ev2;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, rv: 1'b0, kind: KIND_MISS, way: '0, ev: '0, ev2: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign resp_valid = ctl_q.rv;
    assign resp_kind  = ctl_q.kind;
    assign resp_way   = ctl_q.way;
    assign lp_access  = ctl_q.ev.lp;
    assign hp_access  = ctl_q.ev.hp;
    assign policy_on  = move_on;

endmodule

// File: rtl/cs_swap_ctrl_chk.sv
module cs_swap_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       resp_valid,
    input logic [1:0] resp_kind,
    input logic       lp_access,
    input logic       hp_access,
    input logic       policy_on
);

    p_resp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    p_no_resp_unaccepted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid);

    p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_kind != 2'b11));

    p_lp_hit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'b01) |-> (lp_access && !hp_access));

    p_stall_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    p_first_phase_lp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> lp_access);

    p_second_phase_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (lp_access && hp_access));

    p_policy_moves_on_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(policy_on) |-> resp_valid);

    p_events_need_activity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_access || hp_access) |-> (resp_valid || $rose(req_ready)));

endmodule

bind cs_swap_ctrl cs_swap_ctrl_chk u_chk (.*);

// File: tb/tb_cs_swap_ctrl.sv
`timescale 1ns/1ps
module tb_cs_swap_ctrl;

    localparam int SETS = 16, WAYS = 8, LPW = 2, TAG_W = 12, THR = 16, CMAX = 31;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [3:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic resp_valid, lp_access, hp_access, policy_on;
    logic [1:0] resp_kind;
    logic [2:0] resp_way;

    always #2.5 clk = ~clk;

    cs_swap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_set(req_set), .req_tag(req_tag), .resp_valid(resp_valid),
        .resp_kind(resp_kind), .resp_way(resp_way), .lp_access(lp_access),
        .hp_access(hp_access), .policy_on(policy_on)
    );

    typedef struct {
        int kind; int way; bit lp1; bit hp1; bit two; bit lp2; bit hp2; bit pol;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;
    bit pend2 = 0;
    exp_t cur;

    int  m_tag[SETS][WAYS];
    bit  m_val[SETS][WAYS];
    int  m_age[SETS][WAYS];
    int  m_cnt = CMAX;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_touch(input int s, input int w);
        int a = m_age[s][w];
        for (int i = 0; i < WAYS; i++) if (m_age[s][i] < a) m_age[s][i]++;
        m_age[s][w] = 0;
    endtask

    task automatic m_xchg(input int s, input int a, input int b);
        int t; bit v;
        t = m_tag[s][a]; m_tag[s][a] = m_tag[s][b]; m_tag[s][b] = t;
        v = m_val[s][a]; m_val[s][a] = m_val[s][b]; m_val[s][b] = v;
        t = m_age[s][a]; m_age[s][a] = m_age[s][b]; m_age[s][b] = t;
    endtask

    // expected outcome from the requirements (R1, R3-R8, R10)
    task automatic model(input int s, input int t);
        exp_t e;
        int h = -1, lpl = 0, hpl = LPW, vic = -1, old = 0;
        bit on = (m_cnt >= THR);
        e.kind = 0; e.way = 0; e.lp1 = 0; e.hp1 = 0; e.two = 0; e.lp2 = 0; e.hp2 = 0;
        for (int w = 0; w < WAYS; w++) if (m_val[s][w] && m_tag[s][w] == t && h < 0) h = w;
        for (int w = 0; w < LPW; w++) if (m_age[s][w] > m_age[s][lpl]) lpl = w;
        for (int w = LPW; w < WAYS; w++) if (m_age[s][w] > m_age[s][hpl]) hpl = w;
        for (int w = 0; w < WAYS; w++) begin
            if (!m_val[s][w] && vic < 0) vic = w;
            if (m_age[s][w] > m_age[s][old]) old = w;
        end
        if (vic < 0) vic = old;
        if (h >= 0 && h < LPW) begin
            e.kind = 1; e.way = h; e.lp1 = 1; m_touch(s, h);
        end else if (h >= 0 && on) begin
            e.kind = 2; e.way = h; e.lp1 = 1; e.hp1 = 1; e.two = 1; e.lp2 = 1; e.hp2 = 1;
            m_xchg(s, lpl, h); m_touch(s, lpl);
        end else if (h >= 0) begin
            e.kind = 2; e.way = h; e.hp1 = 1; m_touch(s, h);
        end else if (on) begin
            e.way = lpl; e.lp1 = 1; e.two = 1; e.lp2 = 1; e.hp2 = 1;
            m_xchg(s, lpl, hpl); m_tag[s][lpl] = t; m_val[s][lpl] = 1; m_touch(s, lpl);
        end else begin
            e.way = vic; e.lp1 = (vic < LPW); e.hp1 = (vic >= LPW);
            m_tag[s][vic] = t; m_val[s][vic] = 1; m_touch(s, vic);
        end
        if (e.kind == 1) begin if (m_cnt < CMAX) m_cnt++; end
        else if (m_cnt > 0) m_cnt--;
        e.pol = (m_cnt >= THR);
        q.push_back(e);
    endtask

    // driver: called at a falling edge
    task automatic send(input int s, input int t);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_set = 4'(s); req_tag = TAG_W'(t);
        model(s, t);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pend2) begin
                pend2 = 0;
                chk(lp_access == cur.lp2, "R4/R6 second-phase lp_access", lp_access, cur.lp2);
                chk(hp_access == cur.hp2, "R4/R6 second-phase hp_access", hp_access, cur.hp2);
                chk(!resp_valid, "R9 no response in second phase", resp_valid, 0);
            end else if (resp_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R9 response without accepted request", 1, 0);
                end else begin
                    cur = q.pop_front();
                    chk(int'(resp_kind) == cur.kind, "R2 resp_kind", resp_kind, cur.kind);
                    chk(int'(resp_way) == cur.way, "R1/R5 resp_way", resp_way, cur.way);
                    chk(lp_access == cur.lp1, "R3/R8 first-phase lp_access", lp_access, cur.lp1);
                    chk(hp_access == cur.hp1, "R3/R8 first-phase hp_access", hp_access, cur.hp1);
                    chk(policy_on == cur.pol, "R7 policy_on", policy_on, cur.pol);
                    chk(req_ready == !cur.two, "R9 ready during move", req_ready, !cur.two);
                    if (cur.two) pend2 = 1;
                end
            end else if (lp_access || hp_access) begin
                chk(0, "R2 access pulse without activity", {lp_access, hp_access}, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_val[s][w] = 0; m_age[s][w] = w;
            end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1, "R9 reset ready", req_ready, 1);
        chk(resp_valid == 0, "R2 reset resp_valid", resp_valid, 0);
        chk(policy_on == 1, "R7 reset count enables movement", policy_on, 1);
        chk(!lp_access && !hp_access, "R3 reset access pulses", {lp_access, hp_access}, 0);

        // R6: misses fill LP, older blocks pushed into HP
        for (int t = 1; t <= 8; t++) send(0, t);
        // R3: LP hits on the two newest tags
        send(0, 8); send(0, 7); send(0, 8);
        // R5: touch order decides which LP block leaves; R4 swap
        send(0, 7); send(0, 3);
        // R9: request raised while ready is low is ignored
        while (req_ready) @(negedge clk);
        send(0, 5);
        chk(req_ready == 0, "R9 ready low after move", req_ready, 0);
        req_valid = 1'b1; req_set = 4'd0; req_tag = TAG_W'(77);
        @(negedge clk);
        req_valid = 1'b0;
        send(0, 77);   // must be a miss: 77 never entered
        // R10: another set untouched by the above
        send(1, 5); send(1, 5);
        // R7: drive the count to zero with misses (saturation at 0)
        for (int i = 0; i < 40; i++) send(2 + (i % 4), 100 + i);
        chk(policy_on == 0, "R7 movement off after poor reuse", policy_on, 0);
        // R8: conventional behaviour
        send(0, 2); send(0, 2); send(9, 1); send(9, 2); send(0, 200);
        // R7: LP hits bring movement back
        for (int i = 0; i < 20; i++) send(9, (i % 2) + 1);
        // mixed traffic
        r = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            send(int'(r[1:0]), int'(r[7:4]) % 11);
        end
        repeat (6) @(negedge clk);
        chk(q.size() == 0 && !pend2, "R2 every accepted request answered", q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule